// File: doc/BRIEF.md
# Selectable Dual-Output Clock Divider

This block takes one input clock and produces two slower clocks from it. A 2-bit select picks the ratio. The primary output runs at one half, one sixth or one eighth of the input rate. The secondary output always runs at half the primary rate. Its rising edges fall on the same input edge as the primary's rising edges. A fourth select code is a power-down state that holds both outputs low.

All state is clocked by the single input clock, on its rising edge only. The primary is made by toggling a flop every N/2 input edges, so each ratio gives an exact 50% duty cycle. The secondary flop toggles on each primary rising edge.

Output enable is modelled as a separate drive-enable output. It travels with the two clock data outputs, so a pad ring can place both clocks in high impedance together. Disabling the drive leaves the divider running.

The select is expected to be quasi-static, like a strap. When its sampled value changes, the divider restarts cleanly from low. After reset the block assumes code 11, which is the state undriven select pins settle to.

Top module: `dual_clock_divider`

## Requirements
- R1: With select code 2'b11, pri_clk has a period of 2 input cycles and sec_clk a period of 4 input cycles.
- R2: With select code 2'b01, pri_clk has a period of 6 input cycles and sec_clk a period of 12 input cycles.
- R3: With select code 2'b10, pri_clk has a period of 8 input cycles and sec_clk a period of 16 input cycles.
- R4: With select code 2'b00, pri_clk and sec_clk are both held low for as long as the code stays.
- R5: out_drive equals out_en in every cycle. Both clock outputs share this one enable, and clearing it does not disturb the divider sequence.
- R6: sec_clk changes only on an input edge where pri_clk rises, so every sec_clk rising edge coincides with a pri_clk rising edge.
- R7: Each high and each low level of pri_clk lasts exactly N/2 input cycles, where N is the selected ratio.
- R8: On the first rising input edge that samples a new select code, pri_clk and sec_clk go low and the count restarts. Counting the following edges from 1, both clocks rise together on edge N/2.
- R9: While rst_n is low, both clock outputs are low and the stored select is 2'b11. If the select is 2'b11 when reset releases, both clocks first rise on edge 1 after release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_in | input | 1 | Input clock to be divided |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel | input | 2 | Ratio select; 2'b00 is power-down |
| out_en | input | 1 | Active-high output enable for both clocks |
| pri_clk | output | 1 | Primary divided clock data |
| sec_clk | output | 1 | Secondary clock data at half the primary rate |
| out_drive | output | 1 | Drive enable for both clock pads; low means high impedance |

## Verification
The bench walks every select code and predicts each output level cycle by cycle from the edge count since the last restart. A divider with a wrong terminal count would drift off the predicted levels within one period. A divider that toggled the secondary on the primary's falling edge would put the secondary's rising edges half a primary period late, and this shows up as a mismatch on the very first secondary rise.

Select changes land in the middle of a period. A divider that failed to clear on a change would carry a partial count into the new ratio, and the bench would see a runt first pulse. Power-down is entered from a running state, so any output left high would be caught.

The enable is dropped while the clocks are running. The divider data must stay on schedule during this time, which catches any design that gates the divider with the enable.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;
  typedef enum logic [1:0] {
    SEL_OFF  = 2'b00,
    SEL_MID  = 2'b01,
    SEL_SLOW = 2'b10,
    SEL_FAST = 2'b11
  } div_sel_e;

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction
endpackage

// File: rtl/clkdiv_sel_track.sv
module clkdiv_sel_track
  import clkdiv_pkg::*;
(
  input  logic       clk_in,
  input  logic       rst_n,
  input  logic [1:0] sel,
  output div_sel_e   sel_q,
  output logic       restart
);
  // A restart is flagged in the cycle where the live select differs from the stored one.
  assign restart = (sel != sel_q);

  always_ff @(posedge clk_in or negedge rst_n) begin
    if (!rst_n) sel_q <= SEL_FAST;
    else        sel_q <= div_sel_e'(sel);
  end
endmodule

// File: rtl/clkdiv_decode.sv
module clkdiv_decode
  import clkdiv_pkg::*;
#(
  parameter int RATIO_FAST = 2,
  parameter int RATIO_MID  = 6,
  parameter int RATIO_SLOW = 8,
  parameter int CNT_W      = 3
) (
  input  div_sel_e         sel_q,
  output logic [CNT_W-1:0] half_m1,
  output logic             halt
);
  always_comb begin
    halt    = 1'b0;
    half_m1 = '0;
    unique case (sel_q)
      SEL_FAST: half_m1 = CNT_W'(RATIO_FAST / 2 - 1);
      SEL_MID:  half_m1 = CNT_W'(RATIO_MID / 2 - 1);
      SEL_SLOW: half_m1 = CNT_W'(RATIO_SLOW / 2 - 1);
      default:  halt    = 1'b1;
    endcase
  end
endmodule

// File: rtl/clkdiv_primary.sv
module clkdiv_primary #(
  parameter int CNT_W = 3
) (
  input  logic             clk_in,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             halt,
  input  logic [CNT_W-1:0] half_m1,
  output logic             pri_q,
  output logic             rise_stb
);
  logic [CNT_W-1:0] cnt;
  logic             wrap;

  assign wrap     = !restart && !halt && (cnt == half_m1);
  assign rise_stb = wrap && !pri_q;

  always_ff @(posedge clk_in or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      pri_q <= 1'b0;
    end else if (restart || halt) begin
      cnt   <= '0;
      pri_q <= 1'b0;
    end else if (wrap) begin
      cnt   <= '0;
      pri_q <= !pri_q;
    end else begin
      cnt   <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/clkdiv_secondary.sv
module clkdiv_secondary (
  input  logic clk_in,
  input  logic rst_n,
  input  logic restart,
  input  logic halt,
  input  logic rise_stb,
  output logic sec_q
);
  always_ff @(posedge clk_in or negedge rst_n) begin
    if (!rst_n)                sec_q <= 1'b0;
    else if (restart || halt)  sec_q <= 1'b0;
    else if (rise_stb)         sec_q <= !sec_q;
  end
endmodule

// File: rtl/dual_clock_divider.sv
module dual_clock_divider
  import clkdiv_pkg::*;
#(
  parameter int RATIO_FAST = 2,
  parameter int RATIO_MID  = 6,
  parameter int RATIO_SLOW = 8
) (
  input  logic       clk_in,
  input  logic       rst_n,
  input  logic [1:0] sel,
  input  logic       out_en,
  output logic       pri_clk,
  output logic       sec_clk,
  output logic       out_drive
);
  localparam int MAX_HALF = max3(RATIO_FAST, RATIO_MID, RATIO_SLOW) / 2;
  localparam int CNT_W    = $clog2(MAX_HALF + 1);

  div_sel_e         sel_q;
  logic             restart;
  logic             halt;
  logic [CNT_W-1:0] half_m1;
  logic             rise_stb;

  clkdiv_sel_track u_track (
    .clk_in (clk_in),
    .rst_n  (rst_n),
    .sel    (sel),
    .sel_q  (sel_q),
    .restart(restart)
  );

  clkdiv_decode #(
    .RATIO_FAST(RATIO_FAST),
    .RATIO_MID (RATIO_MID),
    .RATIO_SLOW(RATIO_SLOW),
    .CNT_W     (CNT_W)
  ) u_decode (
    .sel_q  (sel_q),
    .half_m1(half_m1),
    .halt   (halt)
  );

  clkdiv_primary #(.CNT_W(CNT_W)) u_pri (
    .clk_in  (clk_in),
    .rst_n   (rst_n),
    .restart (restart),
    .halt    (halt),
    .half_m1 (half_m1),
    .pri_q   (pri_clk),
    .rise_stb(rise_stb)
  );

  clkdiv_secondary u_sec (
    .clk_in  (clk_in),
    .rst_n   (rst_n),
    .restart (restart),
    .halt    (halt),
    .rise_stb(rise_stb),
    .sec_q   (sec_clk)
  );

  // One enable drives both pads; the divider itself never sees it.
  assign out_drive = out_en;
endmodule

// File: rtl/clkdiv_checker.sv
module clkdiv_checker (
  input logic       clk_in,
  input logic       rst_n,
  input logic [1:0] sel,
  input logic [1:0] sel_q,
  input logic       out_en,
  input logic       pri_clk,
  input logic       sec_clk,
  input logic       out_drive
);
  AST_PD_HOLDS_LOW: assert property (@(posedge clk_in) disable iff (!rst_n)
    (sel == 2'b00 && $past(sel) == 2'b00) |-> (!pri_clk && !sec_clk)); // R4

  AST_SEC_RISE_ALIGNED: assert property (@(posedge clk_in) disable iff (!rst_n)
    $rose(sec_clk) |-> $rose(pri_clk)); // R6

  AST_SEC_MOVES_ON_PRI_RISE: assert property (@(posedge clk_in) disable iff (!rst_n)
    (!$stable(sec_clk) && $stable(sel_q)) |-> $rose(pri_clk)); // R6

  AST_SEL_CHANGE_CLEARS: assert property (@(posedge clk_in) disable iff (!rst_n)
    (sel != $past(sel)) |=> (!pri_clk && !sec_clk)); // R8

  AST_DRIVE_OFF_WITH_OE: assert property (@(posedge clk_in) disable iff (!rst_n)
    !out_en |-> !out_drive); // R5
endmodule

bind dual_clock_divider clkdiv_checker u_chk (
  .clk_in   (clk_in),
  .rst_n    (rst_n),
  .sel      (sel),
  .sel_q    (sel_q),
  .out_en   (out_en),
  .pri_clk  (pri_clk),
  .sec_clk  (sec_clk),
  .out_drive(out_drive)
);

// File: tb/tb_dual_clock_divider.sv
module tb_dual_clock_divider;
  logic       clk_in = 1'b0;
  logic       rst_n  = 1'b0;
  logic [1:0] sel    = 2'b11;
  logic       out_en = 1'b1;
  logic       pri_clk, sec_clk, out_drive;
  int checks   = 0;
  int failures = 0;
  bit done     = 0;

  dual_clock_divider dut (
    .clk_in(clk_in), .rst_n(rst_n), .sel(sel), .out_en(out_en),
    .pri_clk(pri_clk), .sec_clk(sec_clk), .out_drive(out_drive)
  );

  always #2.5 clk_in = ~clk_in;

  task automatic chk(input logic got, input logic exp, input string tag, input string what);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%b expected=%b at %0t", tag, what, got, exp, $time);
    end
  endtask

  // h = N/2 of the mode, 0 for power-down. Entered just after a falling edge.
  task automatic run_mode(input logic [1:0] s, input int h, input int ncyc,
                          input logic oe, input bit restart_edge, input string tag);
    logic prev_pri, prev_sec, ep, es;
    int   run_len;
    sel    = s;
    out_en = oe;
    if (restart_edge) begin
      @(posedge clk_in); @(negedge clk_in);
      chk(pri_clk, 1'b0, "R8", "pri after select change");
      chk(sec_clk, 1'b0, "R8", "sec after select change");
    end
    prev_pri = pri_clk;
    prev_sec = sec_clk;
    run_len  = 0;
    for (int n = 1; n <= ncyc; n++) begin
      @(posedge clk_in); @(negedge clk_in);
      ep = (h == 0) ? 1'b0 : 1'(((n / h) % 2));
      es = (h == 0) ? 1'b0 : 1'((((n + h) / (2 * h)) % 2));
      chk(pri_clk, ep, tag, "pri level");
      chk(sec_clk, es, tag, "sec level");
      chk(out_drive, oe, "R5", "drive enable");
      if (sec_clk !== prev_sec) chk(pri_clk && !prev_pri, 1'b1, "R6", "sec moved without pri rise");
      if (h != 0) begin
        if (pri_clk !== prev_pri) begin
          // The first level after a restart spans exactly h edges too.
          chk(1'(run_len + 1 == h), 1'b1, "R7", "pri level length");
          run_len = 0;
        end else run_len++;
      end
      prev_pri = pri_clk;
      prev_sec = sec_clk;
    end
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_in);
    chk(pri_clk, 1'b0, "R9", "pri in reset");
    chk(sec_clk, 1'b0, "R9", "sec in reset");
    rst_n = 1'b1;                             // released right after a falling edge
    run_mode(2'b11, 1, 24, 1'b1, 1'b0, "R9"); // default mode with no restart edge
    run_mode(2'b01, 3, 48, 1'b1, 1'b1, "R2");
    run_mode(2'b10, 4, 64, 1'b1, 1'b1, "R3");
    run_mode(2'b00, 0, 20, 1'b1, 1'b1, "R4");
    run_mode(2'b11, 1, 16, 1'b1, 1'b1, "R1");
    run_mode(2'b01, 3, 36, 1'b0, 1'b1, "R5"); // divider keeps its schedule while disabled
    run_mode(2'b10, 4, 11, 1'b1, 1'b1, "R3"); // leave a level half finished
    run_mode(2'b01, 3, 30, 1'b1, 1'b1, "R8");
    run_mode(2'b10, 4, 5, 1'b0, 1'b1, "R5");
    run_mode(2'b11, 1, 12, 1'b1, 1'b1, "R1");
    run_mode(2'b00, 0, 8, 1'b0, 1'b1, "R4");
    run_mode(2'b10, 4, 40, 1'b1, 1'b1, "R3");
    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule